// File: doc/BRIEF.md
# Direct-Mapped Instruction Fetch Cache with Freeze, Clear and Line Flush

This block sits between a processor's program-fetch port and a slower backing memory. It holds 64 lines of four 32-bit words, indexed directly by address. Hits are answered from local storage. Misses bring in a whole line from the backing memory. A small control interface turns the cache on and off and can lock its contents. It can also invalidate every line, or one line chosen by a separate line-select register.

Freeze mode keeps serving hits, but a miss is only passed through to memory and is never installed. The whole-cache clear walks one line per cycle. While it runs, the control bit reads 1 and every fetch goes through to memory. The clear and flush request bits drop by themselves once their work is done. A clock-enable output lets a gated control domain stop while the cache is disabled.

The fetch address is a 16-bit word address. Bits [1:0] pick the word in the line, bits [7:2] pick the line, and bits [15:8] are the tag.

Top module: `fetch_cache`

## Requirements
- R1: After reset, `cr_rdata` is 0, `fetch_ready` and `mem_valid` are low, and `ctl_clk_en` is high. The control word uses these bits: bit 0 is enable, bit 1 is freeze, bit 2 is clear, bit 3 is line flush and bit 4 is cut-clock.
- R2: While enable (bit 0) is 0, each fetch makes exactly one memory transfer at the fetch address and stores nothing. A later enabled fetch of the same address therefore misses.
- R3: An enabled, unfrozen miss reads the four words of the line from offset 0 to 3, in order, and then returns the requested word. `fetch_ready` is a one-cycle pulse.
- R4: A hit returns the stored word with `fetch_ready` one cycle after the request is presented, and makes no memory transfer.
- R5: While freeze (bit 1) is 1, hits are still served. A miss makes one memory transfer and installs nothing, so the same line misses again once freeze is cleared.
- R6: Writing 1 to clear (bit 2) makes that bit read 1 from the next cycle. It returns to 0 by itself after one line has been invalidated per cycle for all 64 lines, and every line misses afterwards.
- R7: A fetch made while a clear is running makes exactly one memory transfer and fills no line.
- R8: Writing 1 to flush (bit 3) invalidates only the line whose index is held in the line-select register. Other lines keep hitting, and the bit returns to 0 by itself.
- R9: A flush or clear requested during a line fill waits until that fill has finished and been answered. The invalidate then runs before any later fill.
- R10: `ctl_clk_en` is low exactly when cut-clock (bit 4) is 1 and enable is 0.
- R11: A memory request keeps `mem_valid` high and `mem_addr` unchanged until `mem_ready` is seen. Data is taken in the cycle of `mem_valid && mem_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cr_we | input | 1 | Control word write strobe |
| cr_wdata | input | 5 | Control word: enable, freeze, clear, flush, cut-clock |
| cr_rdata | output | 5 | Control word readback, with live clear and flush status |
| fa_we | input | 1 | Line-select register write strobe |
| fa_wdata | input | 6 | Line index to be flushed |
| fetch_valid | input | 1 | Fetch request, held until `fetch_ready` |
| fetch_addr | input | 16 | Fetch word address |
| fetch_ready | output | 1 | One-cycle pulse: `fetch_data` is valid |
| fetch_data | output | 32 | Fetched instruction word |
| mem_valid | output | 1 | Backing memory read request |
| mem_addr | output | 16 | Backing memory word address |
| mem_ready | input | 1 | Memory accepts the request; `mem_rdata` is valid |
| mem_rdata | input | 32 | Backing memory read data |
| ctl_clk_en | output | 1 | Clock enable for the gated control domain |

## Verification
The hardest case to reach is a line invalidate that lands while a fill is still running. In that case the invalidate must wait, and it must still win over the next fill. The bench forks a flush write so that it arrives two cycles into a four-transfer fill of the very line it targets. It then checks three things: the fill delivered all four words, the reply was correct, and the next fetch to that line misses again. A fetch issued straight after a clear write shows how the cache behaves while the walk is still running, because the 64-cycle walk is far longer than one pass-through transfer.

// File: rtl/fc_pkg.sv
package fc_pkg;
    localparam int CR_W   = 5;
    localparam int CR_EN  = 0;
    localparam int CR_FRZ = 1;
    localparam int CR_CLR = 2;
    localparam int CR_FL  = 3;
    localparam int CR_CUT = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_BYP,
        ST_DONE
    } fc_state_e;
endpackage

// File: rtl/fc_tag_store.sv
module fc_tag_store #(
    parameter int LINES = 64,
    parameter int TAG_W = 8,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [TAG_W-1:0] set_tag,
    input  logic             inv_en,
    input  logic [IDX_W-1:0] inv_idx
);
    logic [LINES-1:0]             valid_q, valid_d;
    logic [LINES-1:0][TAG_W-1:0]  tag_q,   tag_d;

    always_comb begin
        valid_d = valid_q;
        tag_d   = tag_q;
        if (set_en) begin
            valid_d[set_idx] = 1'b1;
            tag_d[set_idx]   = set_tag;
        end
        if (inv_en) begin
            valid_d[inv_idx] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            tag_q   <= '0;
        end else begin
            valid_q <= valid_d;
            tag_q   <= tag_d;
        end
    end

    assign lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
endmodule

// File: rtl/fc_data_store.sv
module fc_data_store #(
    parameter int LINES  = 64,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES),
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] store_q [LINES][WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store_q[wr_idx][wr_off] <= wr_data;
        end
    end

    assign rd_data = store_q[rd_idx][rd_off];
endmodule

// File: rtl/fc_clear_walker.sv
module fc_clear_walker #(
    parameter int LINES = 64,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic [IDX_W-1:0] idx
);
    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
    } walk_t;

    walk_t w_q, w_d;

    always_comb begin
        w_d = w_q;
        if (start) begin
            w_d.busy = 1'b1;
            w_d.idx  = '0;
        end else if (w_q.busy) begin
            if (w_q.idx == IDX_W'(LINES - 1)) begin
                w_d.busy = 1'b0;
            end else begin
                w_d.idx = w_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign busy = w_q.busy;
    assign idx  = w_q.idx;
endmodule

// File: rtl/fetch_cache.sv
module fetch_cache
    import fc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int LINES  = 64,
    parameter int WORDS  = 4,
    localparam int IDX_W = $clog2(LINES),
    localparam int OFF_W = $clog2(WORDS),
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cr_we,
    input  logic [CR_W-1:0]   cr_wdata,
    output logic [CR_W-1:0]   cr_rdata,
    input  logic              fa_we,
    input  logic [IDX_W-1:0]  fa_wdata,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_ready,
    output logic [DATA_W-1:0] fetch_data,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              ctl_clk_en
);
    typedef struct packed {
        fc_state_e         state;
        logic              en;
        logic              frz;
        logic              cut;
        logic              clr_pend;
        logic              fl_pend;
        logic [IDX_W-1:0]  fl_idx;
        logic [ADDR_W-1:0] addr;
        logic [OFF_W-1:0]  cnt;
        logic [DATA_W-1:0] rdata;
        logic              ready;
    } regs_t;

    regs_t r_q, r_d;

    logic              look_hit;
    logic [DATA_W-1:0] look_word;
    logic              tag_set;
    logic              inv_flush;
    logic              walk_start;
    logic              walk_busy;
    logic [IDX_W-1:0]  walk_idx;
    logic              data_we;
    logic              filling;
    logic              inv_en;
    logic [IDX_W-1:0]  inv_idx;

    // next-state logic
    always_comb begin
        r_d        = r_q;
        tag_set    = 1'b0;
        inv_flush  = 1'b0;
        walk_start = 1'b0;
        data_we    = 1'b0;

        case (r_q.state)
            ST_IDLE: begin
                if (r_q.clr_pend) begin
                    walk_start = 1'b1;
                    r_d.clr_pend = 1'b0;
                end else if (r_q.fl_pend && !walk_busy) begin
                    inv_flush  = 1'b1;
                    r_d.fl_pend = 1'b0;
                end else if (fetch_valid) begin
                    r_d.addr = fetch_addr;
                    if (r_q.en && look_hit && !walk_busy) begin
                        r_d.rdata = look_word;
                        r_d.ready = 1'b1;
                        r_d.state = ST_DONE;
                    end else if (r_q.en && !r_q.frz && !walk_busy) begin
                        r_d.cnt   = '0;
                        r_d.state = ST_FILL;
                    end else begin
                        r_d.state = ST_BYP;
                    end
                end
            end
            ST_FILL: begin
                if (mem_ready) begin
                    data_we = 1'b1;
                    if (r_q.cnt == r_q.addr[OFF_W-1:0]) begin
                        r_d.rdata = mem_rdata;
                    end
                    if (r_q.cnt == OFF_W'(WORDS - 1)) begin
                        tag_set   = 1'b1;
                        r_d.ready = 1'b1;
                        r_d.state = ST_DONE;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            ST_BYP: begin
                if (mem_ready) begin
                    r_d.rdata = mem_rdata;
                    r_d.ready = 1'b1;
                    r_d.state = ST_DONE;
                end
            end
            default: begin
                r_d.ready = 1'b0;
                r_d.state = ST_IDLE;
            end
        endcase

        // control writes land after the sequencer so a fresh request is kept
        if (cr_we) begin
            r_d.en  = cr_wdata[CR_EN];
            r_d.frz = cr_wdata[CR_FRZ];
            r_d.cut = cr_wdata[CR_CUT];
            if (cr_wdata[CR_CLR]) r_d.clr_pend = 1'b1;
            if (cr_wdata[CR_FL])  r_d.fl_pend  = 1'b1;
        end
        if (fa_we) begin
            r_d.fl_idx = fa_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign filling = (r_q.state == ST_FILL);
    assign inv_en  = walk_busy || inv_flush;
    assign inv_idx = walk_busy ? walk_idx : r_q.fl_idx;

    fc_tag_store #(
        .LINES(LINES),
        .TAG_W(TAG_W)
    ) u_tags (
        .clk    (clk),
        .rst_n  (rst_n),
        .lk_idx (fetch_addr[OFF_W +: IDX_W]),
        .lk_tag (fetch_addr[ADDR_W-1 -: TAG_W]),
        .lk_hit (look_hit),
        .set_en (tag_set),
        .set_idx(r_q.addr[OFF_W +: IDX_W]),
        .set_tag(r_q.addr[ADDR_W-1 -: TAG_W]),
        .inv_en (inv_en),
        .inv_idx(inv_idx)
    );

    fc_data_store #(
        .LINES (LINES),
        .WORDS (WORDS),
        .DATA_W(DATA_W)
    ) u_data (
        .clk    (clk),
        .wr_en  (data_we),
        .wr_idx (r_q.addr[OFF_W +: IDX_W]),
        .wr_off (r_q.cnt),
        .wr_data(mem_rdata),
        .rd_idx (fetch_addr[OFF_W +: IDX_W]),
        .rd_off (fetch_addr[OFF_W-1:0]),
        .rd_data(look_word)
    );

    fc_clear_walker #(
        .LINES(LINES)
    ) u_walk (
        .clk  (clk),
        .rst_n(rst_n),
        .start(walk_start),
        .busy (walk_busy),
        .idx  (walk_idx)
    );

    always_comb begin
        cr_rdata         = '0;
        cr_rdata[CR_EN]  = r_q.en;
        cr_rdata[CR_FRZ] = r_q.frz;
        cr_rdata[CR_CLR] = r_q.clr_pend || walk_busy;
        cr_rdata[CR_FL]  = r_q.fl_pend;
        cr_rdata[CR_CUT] = r_q.cut;
    end

    assign fetch_ready = r_q.ready;
    assign fetch_data  = r_q.rdata;
    assign mem_valid   = (r_q.state == ST_FILL) || (r_q.state == ST_BYP);
    assign mem_addr    = filling ? {r_q.addr[ADDR_W-1:OFF_W], r_q.cnt} : r_q.addr;
    assign ctl_clk_en  = r_q.en || !r_q.cut;
endmodule

// File: rtl/fc_checker.sv
module fc_checker
    import fc_pkg::*;
#(
    parameter int LINES = 64,
    parameter int WORDS = 4,
    localparam int IDX_W = $clog2(LINES),
    localparam int OFF_W = $clog2(WORDS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fetch_ready,
    input logic             mem_valid,
    input logic             mem_ready,
    input logic [OFF_W-1:0] mem_off,
    input logic [CR_W-1:0]  cr_rdata,
    input logic             ctl_clk_en,
    input logic             filling,
    input logic             tag_set,
    input logic             walk_busy,
    input logic [IDX_W-1:0] walk_idx
);
    assert_ready_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_ready |=> !fetch_ready);

    assert_fill_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (filling && mem_valid && mem_ready && mem_off != OFF_W'(WORDS - 1))
        |=> (mem_valid && mem_off == OFF_W'($past(mem_off) + 1'b1)));

    assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_off)));

    assert_no_fill_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(filling) |-> !$past(cr_rdata[CR_FRZ]));

    assert_no_install_in_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tag_set |-> !walk_busy);

    assert_clear_walk_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cr_rdata[CR_CLR]) |-> ($past(walk_idx) == IDX_W'(LINES - 1)));

    assert_flush_after_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cr_rdata[CR_FL]) |-> !$past(filling));

    assert_clk_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_rdata[CR_CUT] && !cr_rdata[CR_EN]) |-> !ctl_clk_en);

    assert_clk_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_rdata[CR_EN] || !cr_rdata[CR_CUT]) |-> ctl_clk_en);
endmodule

bind fetch_cache fc_checker #(
    .LINES(LINES),
    .WORDS(WORDS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_ready(fetch_ready),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_off    (mem_addr[OFF_W-1:0]),
    .cr_rdata   (cr_rdata),
    .ctl_clk_en (ctl_clk_en),
    .filling    (filling),
    .tag_set    (tag_set),
    .walk_busy  (walk_busy),
    .walk_idx   (walk_idx)
);

// File: tb/fetch_cache_bench.sv
module fetch_cache_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] EN  = 5'b00001;
    localparam logic [4:0] FRZ = 5'b00010;
    localparam logic [4:0] CLR = 5'b00100;
    localparam logic [4:0] FL  = 5'b01000;
    localparam logic [4:0] CUT = 5'b10000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cr_we = 1'b0;
    logic [4:0]  cr_wdata = '0;
    logic [4:0]  cr_rdata;
    logic        fa_we = 1'b0;
    logic [5:0]  fa_wdata = '0;
    logic        fetch_valid = 1'b0;
    logic [15:0] fetch_addr = '0;
    logic        fetch_ready;
    logic [31:0] fetch_data;
    logic        mem_valid;
    logic [15:0] mem_addr;
    logic        mem_ready = 1'b1;
    logic [31:0] mem_rdata;
    logic        ctl_clk_en;

    int checks = 0;
    int errors = 0;
    int xfer_cnt = 0;
    logic [15:0] xfer_log[$];
    logic [31:0] exp_q[$];
    string       exp_tag[$];
    logic        stall_on = 1'b0;
    logic [7:0]  lfsr = 8'hA7;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mem_word(input logic [15:0] a);
        return {a ^ 16'h5A3C, a};
    endfunction

    assign mem_rdata = mem_word(mem_addr);

    fetch_cache u_fetch_cache (
        .clk(clk), .rst_n(rst_n),
        .cr_we(cr_we), .cr_wdata(cr_wdata), .cr_rdata(cr_rdata),
        .fa_we(fa_we), .fa_wdata(fa_wdata),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .fetch_ready(fetch_ready), .fetch_data(fetch_data),
        .mem_valid(mem_valid), .mem_addr(mem_addr),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .ctl_clk_en(ctl_clk_en)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory stall pattern
    always @(negedge clk) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_ready = stall_on ? lfsr[0] : 1'b1;
    end

    // transfer monitor
    always @(posedge clk) begin
        if (rst_n && mem_valid && mem_ready) begin
            xfer_cnt++;
            xfer_log.push_back(mem_addr);
        end
    end

    // response scoreboard
    always @(negedge clk) begin
        if (rst_n && fetch_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected response", fetch_data, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = exp_tag.pop_front();
                check(fetch_data == e, t, fetch_data, e);
            end
        end
    end

    task automatic cr_write(input logic [4:0] v);
        @(negedge clk);
        cr_we = 1'b1;
        cr_wdata = v;
        @(negedge clk);
        cr_we = 1'b0;
    endtask

    task automatic fa_write(input logic [5:0] v);
        @(negedge clk);
        fa_we = 1'b1;
        fa_wdata = v;
        @(negedge clk);
        fa_we = 1'b0;
    endtask

    task automatic fetch(input logic [15:0] a, input int exp_xfers, input string req);
        int x0;
        int lat;
        exp_q.push_back(mem_word(a));
        exp_tag.push_back({req, " data"});
        @(negedge clk);
        x0 = xfer_cnt;
        xfer_log.delete();
        fetch_valid = 1'b1;
        fetch_addr = a;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!fetch_ready && lat < 1000);
        fetch_valid = 1'b0;
        check(xfer_cnt - x0 == exp_xfers, {req, " transfers"}, xfer_cnt - x0, exp_xfers);
        if (exp_xfers == 0) begin
            check(lat == 1, {req, " hit latency"}, lat, 1);
        end
        if (exp_xfers == 4) begin
            for (int i = 0; i < 4; i++) begin
                logic [15:0] ea;
                ea = {a[15:2], 2'(i)};
                check(xfer_log.size() > i && xfer_log[i] == ea, {req, " fill order"},
                      (xfer_log.size() > i) ? 32'(xfer_log[i]) : 32'hFFFF, ea);
            end
        end
        if (exp_xfers == 1) begin
            check(xfer_log.size() == 1 && xfer_log[0] == a, {req, " pass-through address"},
                  (xfer_log.size() > 0) ? 32'(xfer_log[0]) : 32'hFFFF, a);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] a_line;
        logic [15:0] b_line;
        logic [15:0] c_line;
        logic [15:0] d_line;
        logic [15:0] e_line;
        logic [15:0] x_addr;
        int waited;
        a_line = 16'h1214;  // index 5
        b_line = 16'h1218;  // index 6
        c_line = 16'h3426;  // index 9, offset 2
        d_line = 16'h5530;  // index 12
        e_line = 16'h6641;  // index 16, offset 1
        x_addr = 16'h7702;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cr_rdata == 5'b0, "R1 control readback", cr_rdata, 0);
        check(!fetch_ready, "R1 fetch_ready", fetch_ready, 0);
        check(!mem_valid, "R1 mem_valid", mem_valid, 0);
        check(ctl_clk_en, "R1 ctl_clk_en", ctl_clk_en, 1);

        // R2 disabled: pure pass-through
        fetch(x_addr, 1, "R2 disabled fetch");
        fetch(x_addr, 1, "R2 disabled repeat");

        // R10 cut-clock with cache disabled
        cr_write(CUT);
        check(!ctl_clk_en, "R10 gated when disabled", ctl_clk_en, 0);
        cr_write(CUT | EN);
        check(ctl_clk_en, "R10 running when enabled", ctl_clk_en, 1);
        cr_write(EN);
        check(ctl_clk_en, "R10 running without cut", ctl_clk_en, 1);

        // R2 nothing stored while disabled; R3 fill; R4 hit
        fetch(x_addr, 4, "R2 first enabled fetch misses");
        fetch(a_line, 4, "R3 miss fill");
        fetch(a_line + 16'd3, 0, "R4 hit same line");
        fetch(b_line + 16'd2, 4, "R3 miss fill requested word 2");
        fetch(b_line, 0, "R4 hit other line");
        fetch(x_addr, 0, "R4 hit earlier line");

        // R5 freeze
        cr_write(EN | FRZ);
        fetch(a_line + 16'd1, 0, "R5 hit while frozen");
        fetch(d_line, 1, "R5 frozen miss");
        fetch(d_line, 1, "R5 frozen miss again");
        cr_write(EN);
        fetch(d_line, 4, "R5 nothing installed while frozen");

        // R8 single-line flush
        fa_write(6'd5);
        cr_write(EN | FL);
        @(negedge clk);
        check(cr_rdata[3] == 1'b0, "R8 flush bit self-clears", cr_rdata, 0);
        fetch(b_line + 16'd1, 0, "R8 neighbour line kept");
        fetch(a_line, 4, "R8 flushed line misses");

        // R9 flush arriving during a fill
        fa_write(6'd9);
        fork
            fetch(c_line, 4, "R9 fill completes");
            begin
                repeat (2) @(negedge clk);
                cr_write(EN | FL);
            end
        join
        repeat (3) @(negedge clk);
        check(cr_rdata[3] == 1'b0, "R9 flush done after fill", cr_rdata, 0);
        fetch(c_line, 4, "R9 invalidate ran after fill");

        // R6 whole clear and R7 fetch during clear
        cr_write(EN | CLR);
        check(cr_rdata[2] == 1'b1, "R6 clear reads 1", cr_rdata, 5'b00101);
        fetch(b_line, 1, "R7 fetch during clear");
        check(cr_rdata[2] == 1'b1, "R6 clear still running", cr_rdata, 5'b00101);
        waited = 0;
        while (cr_rdata[2] && waited < 200) begin
            @(negedge clk);
            waited++;
        end
        check(cr_rdata[2] == 1'b0, "R6 clear self-clears", cr_rdata, 5'b00001);
        check(waited > 40 && waited < 70, "R6 clear duration", waited, 60);
        fetch(b_line, 4, "R6 line invalid after clear");
        fetch(c_line, 4, "R6 other line invalid after clear");

        // R11 stalled memory
        stall_on = 1'b1;
        fetch(e_line, 4, "R11 fill with stalls");
        fetch(16'h0990, 4, "R11 second fill with stalls");
        stall_on = 1'b0;
        fetch(e_line + 16'd2, 0, "R11 hit after stalled fill");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R3 all responses seen", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule